// File: doc/BRIEF.md
# Serial Receiver with Error Flags

This block is the receiving half of an asynchronous serial port. A baud strobe at sixteen times the bit rate drives a receiver that finds the start bit, takes three samples in the middle of every bit, and builds each character from a start bit, eight data bits sent least significant bit first, and one stop bit. A finished character goes into a one-byte holding register and sets a data-ready flag. The block also records three errors. An overrun means a character arrived while the previous one was still unread. A noise error means the mid-bit samples disagreed. A framing error means the stop bit was sampled low.

The host reads the block through two single-cycle strobes, one for status and one for data. Read data is combinational and valid in the same cycle as the strobe. An error flag goes away only after two steps: a status read that sees the flag set, and then a later data read. A flag that sets after the status read therefore survives the next data read, so software can tell that a character was lost. Each error has its own enable input. The enabled errors are ORed together into a single interrupt line.

Top module: `serrx_top`

## Requirements
- R1: A falling edge on the serial input, seen on a baud strobe while idle, starts a character. If the start bit's majority vote is high, the edge is a false start: the receiver goes back to idle and changes no flag and no data.
- R2: A valid character loads its eight data bits, least significant bit first, into the holding register and sets the data-ready flag at status bit 3. A data read returns the byte on rdata_o and clears data-ready.
- R3: Each bit is sampled on strobes 7, 8 and 9 of its 16, and the bit value is the majority of the three samples. If any bit of the character, start and stop included, has samples that disagree, the noise flag (status bit 1) is set.
- R4: A stop bit whose vote is 0 sets the framing flag (status bit 0).
- R5: A character that completes while data-ready is set, with no data read in that cycle, sets the overrun flag (status bit 2). That character is discarded: the holding register keeps its byte, and the noise and framing flags are not touched.
- R6: A status read records each error flag that is set at that moment. The next data read clears exactly those recorded flags and drops all records.
- R7: An error flag that was clear at the last status read is not cleared by the following data read.
- R8: irq_o is high exactly when some error flag is set together with its enable input (ie_ovr_i, ie_noise_i, ie_frame_i).
- R9: Reset clears data-ready, all three error flags and the interrupt.
- R10: A status read returns {zeros, data-ready, overrun, noise, framing} in bits 7..0. A data read returns the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial input, idle high, synchronous to clk |
| tick16_i | input | 1 | Baud strobe at 16 times the bit rate |
| rd_status_i | input | 1 | Status read strobe |
| rd_data_i | input | 1 | Data read strobe |
| ie_ovr_i | input | 1 | Overrun interrupt enable |
| ie_noise_i | input | 1 | Noise interrupt enable |
| ie_frame_i | input | 1 | Framing interrupt enable |
| rdata_o | output | 8 | Read data: status byte or holding register |
| irq_o | output | 1 | Combined error interrupt |

## Verification
A wrong per-flag arm record does not show up at the moment it goes wrong. It shows one status-and-data read pair later, when a flag either stays set or disappears against the model. A bad sample vote or a bad bit count corrupts the byte returned on the very next data read. An overrun that overwrites the register returns the newer byte in place of the older one, and an enable mix-up shows on irq_o as soon as the flag is set.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  typedef struct packed {
    logic ovr;
    logic nse;
    logic frm;
  } err_flags_t;

  // majority of three mid-bit samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // samples disagree when not all equal
  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

endpackage

// File: rtl/serrx_sampler.sv
module serrx_sampler
  import serrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  output logic              done_o,
  output logic [DATA_W-1:0] frame_data_o,
  output logic              frame_noise_o,
  output logic              frame_ferr_o
);
  localparam int CNT_W = $clog2(OSR + 1);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] T_A   = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] T_B   = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] T_C   = CNT_W'(OSR / 2 + 1);
  localparam logic [CNT_W-1:0] T_END = CNT_W'(OSR);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              rx_prev, s_a, s_b, noise_acc;

  // named internal events
  logic [CNT_W-1:0] tnum;
  logic             mid_evt, bit_v, bit_split, start_fail, edge_evt;

  assign tnum       = (cnt == T_END) ? CNT_W'(1) : cnt + CNT_W'(1);
  assign mid_evt    = tick_i && (state != RX_IDLE) && (tnum == T_C);
  assign bit_v      = vote3(s_a, s_b, rx_i);
  assign bit_split  = split3(s_a, s_b, rx_i);
  assign start_fail = mid_evt && (state == RX_START) && bit_v;
  assign edge_evt   = tick_i && (state == RX_IDLE) && rx_prev && !rx_i;

  assign done_o        = mid_evt && (state == RX_STOP);
  assign frame_data_o  = shreg;
  assign frame_noise_o = noise_acc | bit_split;
  assign frame_ferr_o  = !bit_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      rx_prev   <= 1'b1;
      s_a       <= 1'b1;
      s_b       <= 1'b1;
      noise_acc <= 1'b0;
    end else if (tick_i) begin
      rx_prev <= rx_i;
      if (state == RX_IDLE) begin
        if (edge_evt) begin
          state     <= RX_START;
          cnt       <= CNT_W'(1);
          noise_acc <= 1'b0;
        end
      end else begin
        cnt <= tnum;
        if (tnum == T_A) s_a <= rx_i;
        if (tnum == T_B) s_b <= rx_i;
        if (tnum == T_C) begin
          unique case (state)
            RX_START: if (bit_v) state <= RX_IDLE;
                      else noise_acc <= bit_split;
            RX_DATA: begin
              shreg     <= {bit_v, shreg[DATA_W-1:1]};
              noise_acc <= noise_acc | bit_split;
            end
            RX_STOP:  state <= RX_IDLE;
            default:  state <= RX_IDLE;
          endcase
        end
        if (tnum == T_END) begin
          if (state == RX_START) begin
            state   <= RX_DATA;
            bit_idx <= '0;
          end else if (state == RX_DATA) begin
            if (bit_idx == LAST) state <= RX_STOP;
            else bit_idx <= bit_idx + IDX_W'(1);
          end
        end
      end
    end
  end

  // R1: a rejected start returns to idle and produces no character
  assert_false_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_fail |=> (state == RX_IDLE) && !done_o);

  // R1: a character only begins from idle on a falling edge
  assert_start_from_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == RX_IDLE) && (state == RX_START) |-> $past(edge_evt));

endmodule

// File: rtl/serrx_flags.sv
module serrx_flags
  import serrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              frame_noise_i,
  input  logic              frame_ferr_i,
  input  logic              rd_status_i,
  input  logic              rd_data_i,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output err_flags_t        flags_q
);
  err_flags_t arm_q, flags_nxt;
  logic       load_evt, ovr_evt;

  assign load_evt = done_i && (!full_q || rd_data_i);
  assign ovr_evt  = done_i && full_q && !rd_data_i;

  always_comb begin
    flags_nxt = flags_q;
    if (rd_data_i) flags_nxt = flags_q & ~arm_q;
    if (load_evt) begin
      flags_nxt.nse = flags_nxt.nse | frame_noise_i;
      flags_nxt.frm = flags_nxt.frm | frame_ferr_i;
    end
    if (ovr_evt) flags_nxt.ovr = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      flags_q <= '0;
      arm_q   <= '0;
    end else begin
      flags_q <= flags_nxt;
      if (rd_status_i) arm_q <= arm_q | flags_q;
      if (rd_data_i) begin
        arm_q  <= '0;
        full_q <= 1'b0;
      end
      if (load_evt) begin
        data_q <= frame_data_i;
        full_q <= 1'b1;
      end
    end
  end

  // R5: overrunning character leaves the held byte alone and sets overrun
  assert_ovr_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> $stable(data_q) && flags_q.ovr && full_q);

  // R7: an unarmed overrun flag survives a data read
  assert_unarmed_survives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.ovr && rd_data_i && !arm_q.ovr) |=> flags_q.ovr);

  // R6: an armed framing flag clears on the data read unless it sets again
  assert_armed_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && arm_q.frm && !(load_evt && frame_ferr_i)) |=> !flags_q.frm);

  // R3: a noisy accepted character raises the noise flag
  assert_noise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && frame_noise_i) |=> flags_q.nse);

  // R4: a low stop bit on an accepted character raises framing
  assert_frame_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && frame_ferr_i) |=> flags_q.frm);

  // R2: data read with no new character empties the register
  assert_read_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && !done_i) |=> !full_q);

endmodule

// File: rtl/serrx_top.sv
module serrx_top
  import serrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick16_i,
  input  logic              rd_status_i,
  input  logic              rd_data_i,
  input  logic              ie_ovr_i,
  input  logic              ie_noise_i,
  input  logic              ie_frame_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              done_w, noise_w, ferr_w, full_w;
  logic [DATA_W-1:0] frame_w, data_w, status_w;
  err_flags_t        flags_w;

  serrx_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_sampler (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick_i(tick16_i),
    .done_o(done_w), .frame_data_o(frame_w),
    .frame_noise_o(noise_w), .frame_ferr_o(ferr_w)
  );

  serrx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .done_i(done_w), .frame_data_i(frame_w),
    .frame_noise_i(noise_w), .frame_ferr_i(ferr_w),
    .rd_status_i(rd_status_i), .rd_data_i(rd_data_i),
    .data_q(data_w), .full_q(full_w), .flags_q(flags_w)
  );

  assign status_w = {{(DATA_W-4){1'b0}}, full_w, flags_w.ovr, flags_w.nse, flags_w.frm};
  assign rdata_o  = rd_status_i ? status_w : data_w;
  assign irq_o    = (flags_w.ovr & ie_ovr_i) | (flags_w.nse & ie_noise_i) |
                    (flags_w.frm & ie_frame_i);

  // R9: reset leaves every flag and the interrupt low
  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (status_w == '0) && !irq_o);

  // R8: an enabled overrun always reaches the interrupt line
  assert_irq_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_w.ovr && ie_ovr_i) |-> irq_o);

  // R8: with every enable low the interrupt stays quiet
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_ovr_i && !ie_noise_i && !ie_frame_i) |-> !irq_o);

endmodule

// File: tb/serrx_top_bench.sv
`timescale 1ns/1ps
module serrx_top_bench;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, tick = 1'b0;
  logic rd_st = 1'b0, rd_dt = 1'b0, ie_o = 1'b0, ie_n = 1'b0, ie_f = 1'b0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit done_flag = 0;

  // bench-side model of the visible state
  logic [7:0] m_data;
  logic m_full, m_ovr, m_nse, m_frm, a_ovr, a_nse, a_frm;

  serrx_top u_serrx_top (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick16_i(tick),
    .rd_status_i(rd_st), .rd_data_i(rd_dt),
    .ie_ovr_i(ie_o), .ie_noise_i(ie_n), .ie_frame_i(ie_f),
    .rdata_o(rdata), .irq_o(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_status();
    return {4'b0000, m_full, m_ovr, m_nse, m_frm};
  endfunction

  function automatic logic exp_irq();
    return (m_ovr & ie_o) | (m_nse & ie_n) | (m_frm & ie_f);
  endfunction

  task automatic model_reset();
    m_data = 8'h00; m_full = 0; m_ovr = 0; m_nse = 0; m_frm = 0;
    a_ovr = 0; a_nse = 0; a_frm = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic v);
    @(negedge clk); rx = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // noisy_bit: -1 none, 0 start, 1..8 data, 9 stop
  task automatic send_frame(input logic [7:0] d, input logic stop_v, input int noisy_bit);
    for (int b = 0; b < 10; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
      for (int t = 1; t <= 16; t++)
        do_tick((b == noisy_bit && t == 8) ? ~v : v);
    end
    for (int i = 0; i < 4; i++) do_tick(1'b1);
    if (m_full) m_ovr = 1;
    else begin
      m_data = d; m_full = 1;
      m_nse = m_nse | (noisy_bit >= 0);
      m_frm = m_frm | ~stop_v;
    end
  endtask

  task automatic read_status(input string req);
    @(negedge clk); rd_st = 1'b1; #1;
    chk(req, rdata, exp_status());
    a_ovr |= m_ovr; a_nse |= m_nse; a_frm |= m_frm;
    @(negedge clk); rd_st = 1'b0;
  endtask

  task automatic read_data(input string req);
    @(negedge clk); rd_dt = 1'b1; #1;
    chk(req, rdata, m_data);
    if (a_ovr) m_ovr = 0;
    if (a_nse) m_nse = 0;
    if (a_frm) m_frm = 0;
    a_ovr = 0; a_nse = 0; a_frm = 0; m_full = 0;
    @(negedge clk); rd_dt = 1'b0;
  endtask

  task automatic check_irq(input string req);
    @(negedge clk); #1;
    chk(req, irq, exp_irq());
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) do_tick(1'b1);

    // R9 / R10: clean state after reset
    read_status("R9 reset status");
    check_irq("R9 reset irq");

    // R2 / R10: plain character, then read back
    send_frame(8'hA5, 1'b1, -1);
    read_status("R10 status after clean char");
    read_data("R2 data A5");
    read_status("R2 full cleared");

    // R1: false start, low for 6 strobes only
    for (int t = 0; t < 6; t++) do_tick(1'b0);
    for (int t = 0; t < 12; t++) do_tick(1'b1);
    read_status("R1 false start leaves status");

    // R3: noise on the start bit, then on the stop bit
    send_frame(8'h3C, 1'b1, 0);
    read_status("R3 noise on start bit");
    read_data("R3 majority data 3C");
    send_frame(8'hC3, 1'b1, 9);
    read_status("R3 noise on stop bit");
    read_data("R3 data C3");
    read_status("R6 noise cleared by sequence");

    // R4: framing error
    send_frame(8'h81, 1'b0, -1);
    ie_f = 1'b1;
    check_irq("R8 framing irq");
    read_status("R4 framing set");
    read_data("R4 data 81");
    read_status("R6 framing cleared");
    ie_f = 1'b0;

    // R5 / R7: status read before overrun, so data read must not clear it
    send_frame(8'h11, 1'b1, -1);
    read_status("R7 status before overrun");
    send_frame(8'h22, 1'b1, 4);
    ie_o = 1'b1;
    check_irq("R8 overrun irq");
    read_data("R5 held byte survives overrun");
    read_status("R7 overrun survives unarmed read");
    read_data("R6 armed data read");
    read_status("R6 overrun cleared");
    ie_o = 1'b0;

    // random mix
    for (int n = 0; n < 50; n++) begin
      logic [7:0] d;
      int nb;
      d  = 8'($urandom);
      nb = ($urandom % 10 < 3) ? int'($urandom % 10) : -1;
      send_frame(d, ($urandom % 5) != 0, nb);
      ie_o = 1'($urandom); ie_n = 1'($urandom); ie_f = 1'($urandom);
      check_irq("R8 random irq");
      if ($urandom % 3 != 0) read_status("R6 random status");
      if ($urandom % 3 != 0) read_data("R2 random data");
    end

    // R9: reset with flags pending
    send_frame(8'h55, 1'b0, 3);
    send_frame(8'h66, 1'b1, -1);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    model_reset();
    ie_o = 1'b1; ie_n = 1'b1; ie_f = 1'b1;
    check_irq("R9 irq after reset");
    read_status("R9 status after reset");

    finish_run();
  end
endmodule